// File: doc/BRIEF.md
# Two-Wire Bus Master Transmitter

This block drives a two-wire serial bus as a master that only sends. Software sees a data register, a control word (start request, stop request, interrupt flag) and a read-only status byte. After each bus event the block posts a fixed status code and raises its interrupt flag. It then holds the bus, with SCL low, until software writes the control word with the flag bit at zero. The start and stop bits in that write pick the next action.

Both bus lines are open-drain. `scl_o`/`sda_o` at 1 release the line, and at 0 pull it low. The wired levels come back on `scl_in`/`sda_in`. One bit cell spans four quarter-periods of `QTR_CYC` clock cycles each. SDA is updated in the first quarter with SCL low. SCL is high in the second and third quarters, and the line is sampled in the third. An on-chip observer watches the wired lines for START and STOP conditions so that the block knows whether another master owns the bus. The block does no clock stretching.

Top module: `twm_tx_master`

## Requirements
- R1: After reset both line outputs are 1 (released), the interrupt flag is 0, the status byte is F8h (no event pending), and neither the slave-idle nor the receive-handoff output is set.
- R2: Writing control with start=1 while idle and the bus is free generates a START: SDA falls while SCL is high, then SCL falls. The status becomes 08h and the flag is set.
- R3: Once the flag is set it stays set and both line outputs stay frozen until control is written with its flag bit at 0. A write with the flag bit at 1 has no effect on the flag.
- R4: In status 08h or 10h, clearing the flag sends the data register as the address, MSB first, followed by a released ninth bit. A low ninth bit (ACK) gives status 18h, and a high one (NOT ACK) gives 20h.
- R5: In status 18h, 20h, 28h or 30h, clearing the flag with start=0 and stop=0 sends the data register MSB first. The result is status 28h on ACK and 30h on NOT ACK.
- R6: In those four states, start=1 and stop=0 produces a repeated START and status 10h.
- R7: In those four states, start=0 and stop=1 produces a STOP: SDA rises while SCL is high. Hardware then clears the stop bit, the status returns to F8h, and the flag stays 0.
- R8: In those four states, start=1 and stop=1 produces a STOP and then a START. Hardware clears the stop bit, and the result is status 08h with the flag set.
- R9: If the block releases SDA during bits 1 to 8 of a byte but samples it low while SCL is high, it releases both lines. It then reports status 38h with the flag set and enters the slave-idle state.
- R10: In the slave-idle state both lines stay released. If the flag is cleared with start=1, a START is generated only after a STOP has been observed on the bus, and the result is status 08h.
- R11: If the data register's bit 0 is 1 (a read address) when the flag is cleared in status 08h or 10h, the block raises the receive-handoff output. It sends no address and freezes both lines.
- R12: Apart from generating START, repeated START and STOP, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_we | input | 1 | Write strobe for the data register |
| dat_wr | input | 8 | Data register write value |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_sta_wr | input | 1 | Start-request bit written |
| ctl_sto_wr | input | 1 | Stop-request bit written |
| ctl_flag_wr | input | 1 | Interrupt flag bit written (0 clears, 1 leaves it) |
| status | output | 8 | Status code of the last event |
| irq | output | 1 | Interrupt flag |
| sto_bit | output | 1 | Current stop-request bit |
| slave_idle | output | 1 | Bus given up after arbitration loss |
| rx_handoff | output | 1 | Read address seen; receive logic takes over |
| scl_in | input | 1 | Wired SCL level |
| sda_in | input | 1 | Wired SDA level |
| scl_o | output | 1 | SCL drive (1 = release) |
| sda_o | output | 1 | SDA drive (1 = release) |

## Verification
Losing arbitration and then waiting for a free bus is the hardest path to reach from the ports. It needs a second bus driver that holds SDA low against a released bit, followed later by a STOP that the block did not generate. The bench has a separate pull-down on its wired SDA model. It enables this pull-down after a START while SCL is low, so the first 1 bit of the address is lost. It then clears the flag with start=1, confirms that nothing happens while the pull-down holds the bus busy, and releases the pull-down so that SDA rises with SCL high. That rising edge is the STOP the block has to see before it starts again.

// File: rtl/twm_pkg.sv
package twm_pkg;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_D_ACK   = 8'h28;
  localparam logic [7:0] ST_D_NACK  = 8'h30;
  localparam logic [7:0] ST_ARB     = 8'h38;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_BIT, E_STOP, E_RSTART, E_HOLD, E_LOST, E_RX
  } eng_t;

  // status code posted when a nine-bit transfer completes
  function automatic logic [7:0] byte_code(input logic was_addr, input logic nack);
    if (was_addr) byte_code = nack ? ST_AW_NACK : ST_AW_ACK;
    else          byte_code = nack ? ST_D_NACK  : ST_D_ACK;
  endfunction

  // the next byte is an address after a START or a repeated START
  function automatic logic addr_pending(input logic [7:0] code);
    addr_pending = (code == ST_START) || (code == ST_RSTART);
  endfunction

  // released high by us but seen low on the wire
  function automatic logic lost_arb(input logic driven, input logic seen);
    lost_arb = driven && !seen;
  endfunction

endpackage

// File: rtl/twm_qdiv.sv
module twm_qdiv #(
  parameter int QTR_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic qtick
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign qtick = (cnt == LAST);
endmodule

// File: rtl/twm_cond_det.sv
module twm_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy,
  output logic stop_det
);
  logic scl_q, sda_q, start_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  assign start_det = scl_in && scl_q && sda_q && !sda_in;
  assign stop_det  = scl_in && scl_q && !sda_q && sda_in;
endmodule

// File: rtl/twm_tx_master.sv
module twm_tx_master
  import twm_pkg::*;
#(
  parameter int QTR_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dat_we,
  input  logic [7:0] dat_wr,
  input  logic       ctl_we,
  input  logic       ctl_sta_wr,
  input  logic       ctl_sto_wr,
  input  logic       ctl_flag_wr,
  output logic [7:0] status,
  output logic       irq,
  output logic       sto_bit,
  output logic       slave_idle,
  output logic       rx_handoff,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_o,
  output logic       sda_o
);
  localparam int NBITS = 9;
  localparam logic [3:0] LAST_BIT = 4'(NBITS - 1);

  eng_t       st;
  logic [1:0] q;
  logic [3:0] nbit;
  logic [8:0] sh;
  logic [7:0] dat_r, code;
  logic       flag, sta_r, sto_r, scl_r, sda_r, addr_byte, nack_r;
  logic       qtick, busy, stop_det;
  logic       arb_lost, evt_done, in_cond;

  twm_qdiv #(.QTR_CYC(QTR_CYC)) u_div (.clk(clk), .rst_n(rst_n), .qtick(qtick));

  twm_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .busy(busy), .stop_det(stop_det)
  );

  // named events for the checker
  assign arb_lost = (st == E_BIT) && qtick && (q == 2'd2) && (nbit < LAST_BIT)
                    && lost_arb(sh[8], sda_in);
  assign evt_done = qtick && (q == 2'd3) &&
                    ((st == E_START) || (st == E_RSTART) || ((st == E_BIT) && (nbit == LAST_BIT)));
  assign in_cond  = (st == E_START) || (st == E_STOP) || (st == E_RSTART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; q <= 2'd0; nbit <= 4'd0; sh <= '1;
      dat_r <= 8'h00; code <= ST_IDLE; flag <= 1'b0;
      sta_r <= 1'b0; sto_r <= 1'b0; scl_r <= 1'b1; sda_r <= 1'b1;
      addr_byte <= 1'b0; nack_r <= 1'b0;
    end else begin
      if (dat_we) dat_r <= dat_wr;
      if (ctl_we) begin
        sta_r <= ctl_sta_wr;
        sto_r <= ctl_sto_wr;
        if (!ctl_flag_wr) flag <= 1'b0;
      end
      if (evt_done) flag <= 1'b1;

      case (st)
        E_IDLE, E_LOST: begin
          if (sta_r && !busy && !flag) begin
            st <= E_START;
            q  <= 2'd0;
          end
        end
        E_HOLD: begin
          if (!flag) begin
            q <= 2'd0;
            if (addr_pending(code)) begin
              if (dat_r[0]) st <= E_RX;
              else begin
                sh <= {dat_r, 1'b1}; nbit <= 4'd0; addr_byte <= 1'b1; st <= E_BIT;
              end
            end else if (sto_r) st <= E_STOP;
            else if (sta_r)     st <= E_RSTART;
            else begin
              sh <= {dat_r, 1'b1}; nbit <= 4'd0; addr_byte <= 1'b0; st <= E_BIT;
            end
          end
        end
        E_START: if (qtick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: begin scl_r <= 1'b1; sda_r <= 1'b1; end
            2'd1: sda_r <= 1'b0;
            2'd2: scl_r <= 1'b0;
            default: begin code <= ST_START; st <= E_HOLD; end
          endcase
        end
        E_RSTART: if (qtick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_r <= 1'b1;
            2'd1: scl_r <= 1'b1;
            2'd2: sda_r <= 1'b0;
            default: begin scl_r <= 1'b0; code <= ST_RSTART; st <= E_HOLD; end
          endcase
        end
        E_STOP: if (qtick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_r <= 1'b0;
            2'd1: scl_r <= 1'b1;
            2'd2: sda_r <= 1'b1;
            default: begin
              sto_r <= 1'b0;
              if (sta_r) begin st <= E_START; q <= 2'd0; end
              else begin st <= E_IDLE; code <= ST_IDLE; end
            end
          endcase
        end
        E_BIT: if (qtick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_r <= sh[8];
            2'd1: scl_r <= 1'b1;
            2'd2: begin
              if (arb_lost) begin
                scl_r <= 1'b1; sda_r <= 1'b1; code <= ST_ARB;
                flag <= 1'b1; st <= E_LOST;
              end else if (nbit == LAST_BIT) nack_r <= sda_in;
            end
            default: begin
              scl_r <= 1'b0;
              sh    <= {sh[7:0], 1'b1};
              if (nbit == LAST_BIT) begin
                code <= byte_code(addr_byte, nack_r);
                st   <= E_HOLD;
              end else nbit <= nbit + 4'd1;
            end
          endcase
        end
        default: ;  // E_RX: receive logic owns the bus
      endcase
    end
  end

  assign status     = code;
  assign irq        = flag;
  assign sto_bit    = sto_r;
  assign slave_idle = (st == E_LOST);
  assign rx_handoff = (st == E_RX);
  assign scl_o      = scl_r;
  assign sda_o      = sda_r;
endmodule

// File: rtl/twm_tx_checker.sv
module twm_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_o,
  input logic       sda_o,
  input logic       irq,
  input logic       ctl_we,
  input logic       ctl_flag_wr,
  input logic [7:0] status,
  input logic       slave_idle,
  input logic       rx_handoff,
  input logic       arb_lost,
  input logic       evt_done,
  input logic       in_cond
);
  assert_flag_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(ctl_we && !ctl_flag_wr) |=> irq);

  assert_lines_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq && $past(irq) |-> $stable(scl_o) && $stable(sda_o));

  assert_event_raises_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> irq);

  assert_code_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status == 8'h08) || (status == 8'h10) || (status == 8'h18) ||
                   (status == 8'h20) || (status == 8'h28) || (status == 8'h30) ||
                   (status == 8'h38));

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> scl_o && sda_o && irq && slave_idle && (status == 8'h38));

  assert_slave_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slave_idle |-> scl_o && sda_o);

  assert_handoff_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_handoff |=> rx_handoff && $stable(scl_o) && $stable(sda_o));

  assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    scl_o && $past(scl_o) && (sda_o != $past(sda_o)) |-> $past(in_cond));
endmodule

bind twm_tx_master twm_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o), .irq(irq),
  .ctl_we(ctl_we), .ctl_flag_wr(ctl_flag_wr), .status(status),
  .slave_idle(slave_idle), .rx_handoff(rx_handoff), .arb_lost(arb_lost),
  .evt_done(evt_done), .in_cond(in_cond)
);

// File: tb/twm_tx_master_tb.sv
`timescale 1ns/1ps
module twm_tx_master_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       dat_we = 1'b0, ctl_we = 1'b0, ctl_sta_wr = 1'b0, ctl_sto_wr = 1'b0, ctl_flag_wr = 1'b0;
  logic [7:0] dat_wr = 8'h00;
  logic [7:0] status;
  logic       irq, sto_bit, slave_idle, rx_handoff, scl_o, sda_o;
  logic       ack_pull = 1'b0, rogue_pull = 1'b0, ack_mode = 1'b1;
  logic       scl_line, sda_line;

  assign scl_line = scl_o;
  assign sda_line = sda_o & ~ack_pull & ~rogue_pull;

  twm_tx_master #(.QTR_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .dat_wr(dat_wr),
    .ctl_we(ctl_we), .ctl_sta_wr(ctl_sta_wr), .ctl_sto_wr(ctl_sto_wr),
    .ctl_flag_wr(ctl_flag_wr), .status(status), .irq(irq), .sto_bit(sto_bit),
    .slave_idle(slave_idle), .rx_handoff(rx_handoff),
    .scl_in(scl_line), .sda_in(sda_line), .scl_o(scl_o), .sda_o(sda_o)
  );

  // bus observer and acknowledging receiver
  logic       scl_q = 1'b1, sda_q = 1'b1;
  logic [3:0] bitcnt = 4'd0;
  logic [7:0] rxbyte = 8'h00, last_byte = 8'h00;
  int         nstart = 0, nstop = 0, nbytes = 0;

  always @(negedge clk) begin
    scl_q <= scl_line;
    sda_q <= sda_line;
    if (scl_line && scl_q && sda_q && !sda_line) begin
      nstart <= nstart + 1; bitcnt <= 4'd0;
    end else if (scl_line && scl_q && !sda_q && sda_line) begin
      nstop <= nstop + 1; bitcnt <= 4'd0;
    end else if (scl_line && !scl_q) begin
      if (bitcnt == 4'd8) begin
        last_byte <= rxbyte; nbytes <= nbytes + 1; bitcnt <= 4'd0;
      end else begin
        rxbyte <= {rxbyte[6:0], sda_line}; bitcnt <= bitcnt + 4'd1;
      end
    end else if (!scl_line && scl_q) begin
      ack_pull <= (bitcnt == 4'd8) ? ack_mode : 1'b0;
    end
  end

  int total = 0, bad = 0;
  logic done = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_dat(input logic [7:0] d);
    @(negedge clk); dat_we = 1'b1; dat_wr = d;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic sta, input logic sto, input logic fl);
    @(negedge clk); ctl_we = 1'b1; ctl_sta_wr = sta; ctl_sto_wr = sto; ctl_flag_wr = fl;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    for (int k = 0; k < 3000 && !irq; k++) @(negedge clk);
    chk(irq, req, {31'd0, irq}, 32'd1);
  endtask

  function automatic string tag_of(input logic sto, input logic [7:0] e);
    case (e)
      8'h08:        return sto ? "R8" : "R2";
      8'h10:        return "R6";
      8'h18, 8'h20: return "R4";
      8'h28, 8'h30: return "R5";
      default:      return "R7";
    endcase
  endfunction

  typedef struct packed {
    logic       sta;
    logic       sto;
    logic [7:0] dat;
    logic       ack;
    logic [7:0] exp;
    logic       chkb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 8'h00, 1'b1, 8'h08, 1'b0},
    '{1'b0, 1'b0, 8'h5A, 1'b1, 8'h18, 1'b1},
    '{1'b0, 1'b0, 8'hC3, 1'b1, 8'h28, 1'b1},
    '{1'b0, 1'b0, 8'h3C, 1'b0, 8'h30, 1'b1},
    '{1'b1, 1'b0, 8'h00, 1'b1, 8'h10, 1'b0},
    '{1'b0, 1'b0, 8'h92, 1'b0, 8'h20, 1'b1},
    '{1'b0, 1'b0, 8'h81, 1'b1, 8'h28, 1'b1},
    '{1'b1, 1'b1, 8'h00, 1'b1, 8'h08, 1'b0},
    '{1'b0, 1'b0, 8'h44, 1'b1, 8'h18, 1'b1},
    '{1'b0, 1'b1, 8'h00, 1'b1, 8'hF8, 1'b0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int nb0, ns0, nst0;
    logic s0, d0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(scl_o && sda_o, "R1", {30'd0, scl_o, sda_o}, 32'h3);
    chk(!irq, "R1", {31'd0, irq}, 32'd0);
    chk(status == 8'hF8, "R1", {24'd0, status}, 32'hF8);
    chk(!slave_idle && !rx_handoff, "R1", {30'd0, slave_idle, rx_handoff}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      ack_mode = VEC[i].ack;
      nb0 = nbytes; ns0 = nstop;
      wr_dat(VEC[i].dat);
      wr_ctl(VEC[i].sta, VEC[i].sto, 1'b0);
      if (VEC[i].exp == 8'hF8) begin
        repeat (300) @(negedge clk);
        chk(!irq, "R7", {31'd0, irq}, 32'd0);
      end else wait_irq(tag_of(VEC[i].sto, VEC[i].exp));
      chk(status == VEC[i].exp, tag_of(VEC[i].sto, VEC[i].exp), {24'd0, status}, {24'd0, VEC[i].exp});
      if (VEC[i].chkb) begin
        chk(last_byte == VEC[i].dat, tag_of(VEC[i].sto, VEC[i].exp), {24'd0, last_byte}, {24'd0, VEC[i].dat});
        chk(nbytes == nb0 + 1, tag_of(VEC[i].sto, VEC[i].exp), nbytes, nb0 + 1);
      end
      if (VEC[i].sto) begin
        chk(nstop == ns0 + 1, tag_of(VEC[i].sto, VEC[i].exp), nstop, ns0 + 1);
        chk(!sto_bit, tag_of(VEC[i].sto, VEC[i].exp), {31'd0, sto_bit}, 32'd0);
      end
    end
    // R12: only the three intended START conditions appeared on the wire
    chk(nstart == 3, "R12", nstart, 3);

    // R3: flag and lines hold without a clearing write; flag=1 write ignored
    wr_ctl(1'b1, 1'b0, 1'b0);
    wait_irq("R2");
    s0 = scl_o; d0 = sda_o;
    repeat (200) @(negedge clk);
    chk(irq && scl_o == s0 && sda_o == d0, "R3", {29'd0, irq, scl_o, sda_o}, {29'd0, 1'b1, s0, d0});
    wr_ctl(1'b0, 1'b0, 1'b1);
    repeat (60) @(negedge clk);
    chk(irq && status == 8'h08, "R3", {23'd0, irq, status}, {23'd0, 1'b1, 8'h08});
    chk(scl_o == s0 && sda_o == d0, "R3", {30'd0, scl_o, sda_o}, {30'd0, s0, d0});

    // R9: another driver holds SDA low against our first released address bit
    rogue_pull = 1'b1;
    wr_dat(8'hA0);
    wr_ctl(1'b0, 1'b0, 1'b0);
    wait_irq("R9");
    chk(status == 8'h38, "R9", {24'd0, status}, 32'h38);
    chk(slave_idle && scl_o && sda_o, "R9", {29'd0, slave_idle, scl_o, sda_o}, 32'h7);

    // R10: start request waits for a STOP on the bus
    nst0 = nstart;
    wr_ctl(1'b1, 1'b0, 1'b0);
    repeat (200) @(negedge clk);
    chk(nstart == nst0 && slave_idle && !irq, "R10", nstart, nst0);
    chk(status == 8'h38, "R10", {24'd0, status}, 32'h38);
    rogue_pull = 1'b0;
    wait_irq("R10");
    chk(status == 8'h08 && !slave_idle, "R10", {23'd0, slave_idle, status}, 32'h08);
    chk(nstart == nst0 + 1, "R10", nstart, nst0 + 1);

    // R11: read address hands off without sending anything
    nb0 = nbytes;
    wr_dat(8'hA1);
    wr_ctl(1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk(rx_handoff && !irq, "R11", {30'd0, rx_handoff, irq}, 32'h2);
    s0 = scl_o; d0 = sda_o;
    repeat (150) @(negedge clk);
    chk(nbytes == nb0, "R11", nbytes, nb0);
    chk(rx_handoff && scl_o == s0 && sda_o == d0, "R11", {29'd0, rx_handoff, scl_o, sda_o}, {29'd0, 1'b1, s0, d0});

    finish_run();
  end
endmodule